// File: doc/BRIEF.md
# PLL Operating Mode Controller

This block is the mode sequencer for a line-card phase-locked loop. It decides on every clock edge whether the loop is held in reset, running free, locked to its reference, holding its last frequency by request, or holding automatically because the reference dropped out. Software or a supervisor steers it through a two-bit mode-select field. The reference monitors report on the input side through a failure flag, a phase-hit pulse, a reference-select line and a two-bit code that names the reference frequency.

While the controller is holding automatically, a hit-free qualification counter decides when it may lock again. The counter needs a run of consecutive clean cycles. The length of that run depends on the reference frequency. When the run is complete, the controller raises a qualification flag and goes back to Normal on the next edge. A mode-select code forces Free-run from any state, and it overrides every other cause of a transition.

Top module: `pll_mode_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is Reset (`state_code` 3'b011) and `qual_done` is 0.
- R2: From Reset, the first edge with `rst` low moves the controller to Free-run (3'b010), whatever the other inputs are.
- R3: `mode_sel` 2'b10 moves the controller to Free-run on the next edge from every state.
- R4: In Free-run, `mode_sel` 2'b00 leads to Normal (3'b000) and 2'b01 leads to Holdover (3'b001). A change of `ref_sel` in Free-run is ignored.
- R5: In Normal, Holdover or Auto Holdover, either `mode_sel` 2'b01 or a toggle of `ref_sel` since the previous edge leads to Holdover.
- R6: In Normal with `mode_sel` 2'b00, a rise of `ref_fail` from 0 to 1 leads to Auto Holdover (3'b100). A `ref_fail` that stays high without rising leaves the controller in Normal.
- R7: In Auto Holdover, the counter advances once for each cycle in which `ref_fail` and `phase_hit` are both 0. It clears on any cycle with a hit or a failure. `qual_done` is 1 once the count reaches the run length for the registered `ref_freq` code: 00 = 8 kHz needs 1 cycle, 01 = 1.544 MHz needs 64, 10 = 2.048 MHz needs 64 and 11 = 19.44 MHz needs 512. `qual_done` is 1 only in Auto Holdover.
- R8: In Auto Holdover with `mode_sel` 2'b00 and no `ref_sel` toggle, the controller moves to Normal on the edge after `qual_done` is seen high, and never before.
- R9: In Holdover with `mode_sel` 2'b00, the controller moves to Normal only in a cycle when `ref_fail` is 0.
- R10: `mode_sel` 2'b11 holds the current state, except that Reset still leaves for Free-run.
- R11: A forced Free-run beats a Holdover request or a `ref_sel` toggle. Either of those beats any automatic transition caused by the reference in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Mode request: 00 automatic, 01 holdover, 10 free-run, 11 keep state |
| ref_sel | input | 1 | Reference selection; any toggle counts as a reference change |
| ref_fail | input | 1 | Reference reported failed |
| phase_hit | input | 1 | Phase hit seen on the reference this cycle |
| ref_freq | input | 2 | Reference frequency code, registered before use |
| state_code | output | 3 | Current state: 000 Normal, 001 Holdover, 010 Free-run, 011 Reset, 100 Auto Holdover |
| qual_done | output | 1 | Hit-free run complete during Auto Holdover |

## Verification
The bench times the qualification run at each frequency code. A counter with an off-by-one error would raise `qual_done` or relock one cycle early or late, and the 512-cycle case catches a counter that is too narrow. A hit or a failure injected just before the terminal count checks the clearing rule; a design that only paused the count would relock too soon. The bench also drives `ref_fail` high on entry to Normal with no rise and expects no Auto Holdover, which a level-sensitive design would get wrong. It sets up same-cycle conflicts (forced Free-run with a `ref_sel` toggle, a Holdover request together with a failure rise) to expose a wrong priority order. A `ref_sel` toggle in Free-run is also driven, to catch a design that wrongly falls into Holdover there.

// File: rtl/pll_mode_pkg.sv
package pll_mode_pkg;

  typedef enum logic [2:0] {
    ST_NORMAL = 3'b000,
    ST_HOLD   = 3'b001,
    ST_FREE   = 3'b010,
    ST_RESET  = 3'b011,
    ST_AUTO   = 3'b100
  } op_state_e;

  localparam logic [1:0] MS_AUTO = 2'b00;
  localparam logic [1:0] MS_HOLD = 2'b01;
  localparam logic [1:0] MS_FREE = 2'b10;
  localparam logic [1:0] MS_KEEP = 2'b11;

  // Hit-free run length for a frequency code, lengths supplied per code.
  function automatic int unsigned hitfree_len(input logic [1:0] code,
                                              input int unsigned len_8k,
                                              input int unsigned len_t1,
                                              input int unsigned len_e1,
                                              input int unsigned len_oc);
    case (code)
      2'b00:   return len_8k;
      2'b01:   return len_t1;
      2'b10:   return len_e1;
      default: return len_oc;
    endcase
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/pll_ref_watch.sv
module pll_ref_watch (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_sel,
  input  logic       ref_fail,
  input  logic [1:0] ref_freq,
  output logic       sel_change,
  output logic       fail_rise,
  output logic [1:0] freq_q
);
  logic sel_q;
  logic fail_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b0;
      fail_q <= 1'b0;
      freq_q <= 2'b00;
    end else begin
      sel_q  <= ref_sel;
      fail_q <= ref_fail;
      freq_q <= ref_freq;
    end
  end

  assign sel_change = ref_sel ^ sel_q;
  assign fail_rise  = ref_fail & ~fail_q;

endmodule

// File: rtl/pll_hitfree_qual.sv
module pll_hitfree_qual #(
  parameter int unsigned LEN_8K = 1,
  parameter int unsigned LEN_T1 = 64,
  parameter int unsigned LEN_E1 = 64,
  parameter int unsigned LEN_OC = 512
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       count_en,
  input  logic       clean,
  input  logic [1:0] freq_q,
  output logic       qual_done
);
  import pll_mode_pkg::*;

  localparam int unsigned MAXLEN = max4(LEN_8K, LEN_T1, LEN_E1, LEN_OC);
  localparam int CNT_W = $clog2(MAXLEN + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] term;

  assign term = CNT_W'(hitfree_len(freq_q, LEN_8K, LEN_T1, LEN_E1, LEN_OC));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (!count_en || !clean) begin
      cnt <= '0;
    end else if (cnt >= term) begin
      cnt <= term;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign qual_done = (cnt >= term);

  // R7: a dirty cycle during qualification restarts the run
  a_r7_hit_clears: assert property (@(posedge clk) disable iff (rst)
    (count_en && !clean) |=> (cnt == '0));

  // R7: count never exceeds the longest run length
  a_r7_cnt_capped: assert property (@(posedge clk) disable iff (rst)
    (32'(cnt) <= MAXLEN));

endmodule

// File: rtl/pll_mode_fsm.sv
module pll_mode_fsm (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               mode_sel,
  input  logic                     sel_change,
  input  logic                     fail_rise,
  input  logic                     ref_fail,
  input  logic                     qual_done,
  output pll_mode_pkg::op_state_e  state,
  output logic                     stay_auto
);
  import pll_mode_pkg::*;

  op_state_e nxt;

  always_comb begin
    nxt = state;
    if (state == ST_RESET) begin
      nxt = ST_FREE;
    end else if (mode_sel == MS_FREE) begin
      nxt = ST_FREE;
    end else if (mode_sel == MS_KEEP) begin
      nxt = state;
    end else if (state == ST_FREE) begin
      nxt = (mode_sel == MS_HOLD) ? ST_HOLD : ST_NORMAL;
    end else if (mode_sel == MS_HOLD || sel_change) begin
      nxt = ST_HOLD;
    end else begin
      case (state)
        ST_NORMAL: if (fail_rise) nxt = ST_AUTO;
        ST_HOLD:   if (!ref_fail) nxt = ST_NORMAL;
        ST_AUTO:   if (qual_done) nxt = ST_NORMAL;
        default:   nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_RESET;
    else     state <= nxt;
  end

  assign stay_auto = (state == ST_AUTO) && (nxt == ST_AUTO);

  a_r2_reset_exit: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RESET) |=> (state == ST_FREE));

  a_r3_force_free: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == MS_FREE) |=> (state == ST_FREE));

  a_r5_hold_request: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == MS_HOLD && state != ST_RESET) |=> (state == ST_HOLD));

  a_r7_done_only_auto: assert property (@(posedge clk) disable iff (rst)
    qual_done |-> (state == ST_AUTO));

  a_r8_relock: assert property (@(posedge clk) disable iff (rst)
    (state == ST_AUTO && mode_sel == MS_AUTO && !sel_change && qual_done)
      |=> (state == ST_NORMAL));

  a_r8_no_early_relock: assert property (@(posedge clk) disable iff (rst)
    (state == ST_AUTO && mode_sel == MS_AUTO && !sel_change && !qual_done)
      |=> (state == ST_AUTO));

  a_r10_keep: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == MS_KEEP && state != ST_RESET) |=> $stable(state));

endmodule

// File: rtl/pll_mode_ctrl.sv
module pll_mode_ctrl #(
  parameter int unsigned LEN_8K = 1,
  parameter int unsigned LEN_T1 = 64,
  parameter int unsigned LEN_E1 = 64,
  parameter int unsigned LEN_OC = 512
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_sel,
  input  logic       ref_sel,
  input  logic       ref_fail,
  input  logic       phase_hit,
  input  logic [1:0] ref_freq,
  output logic [2:0] state_code,
  output logic       qual_done
);
  import pll_mode_pkg::*;

  logic      sel_change;
  logic      fail_rise;
  logic [1:0] freq_q;
  logic      stay_auto;
  op_state_e state;

  pll_ref_watch u_watch (
    .clk        (clk),
    .rst        (rst),
    .ref_sel    (ref_sel),
    .ref_fail   (ref_fail),
    .ref_freq   (ref_freq),
    .sel_change (sel_change),
    .fail_rise  (fail_rise),
    .freq_q     (freq_q)
  );

  pll_hitfree_qual #(
    .LEN_8K (LEN_8K),
    .LEN_T1 (LEN_T1),
    .LEN_E1 (LEN_E1),
    .LEN_OC (LEN_OC)
  ) u_qual (
    .clk       (clk),
    .rst       (rst),
    .count_en  (stay_auto),
    .clean     (!ref_fail && !phase_hit),
    .freq_q    (freq_q),
    .qual_done (qual_done)
  );

  pll_mode_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .mode_sel   (mode_sel),
    .sel_change (sel_change),
    .fail_rise  (fail_rise),
    .ref_fail   (ref_fail),
    .qual_done  (qual_done),
    .state      (state),
    .stay_auto  (stay_auto)
  );

  assign state_code = state;

endmodule

// File: tb/test_pll_mode_ctrl.sv
module test_pll_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] mode_sel;
  logic       ref_sel;
  logic       ref_fail;
  logic       phase_hit;
  logic [1:0] ref_freq;
  logic [2:0] state_code;
  logic       qual_done;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pll_mode_ctrl i_pll_mode_ctrl (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .ref_sel(ref_sel),
    .ref_fail(ref_fail), .phase_hit(phase_hit), .ref_freq(ref_freq),
    .state_code(state_code), .qual_done(qual_done)
  );

  localparam logic [2:0] E_NORM = 3'b000, E_HOLD = 3'b001, E_FREE = 3'b010,
                         E_RST = 3'b011, E_AUTO = 3'b100;

  // bench model state
  logic [2:0] m_st;
  int         m_cnt;
  logic       m_psel, m_pfail;
  logic [1:0] m_fq;

  function automatic int run_len(input logic [1:0] c);
    if (c == 2'd0) return 1;
    if (c == 2'd3) return 512;
    return 64;
  endfunction

  function automatic logic [2:0] next_st(input logic [2:0] s, input logic [1:0] ms,
                                         input logic chg, input logic rise,
                                         input logic fl, input logic qd);
    if (s == E_RST) return E_FREE;
    if (ms == 2'b10) return E_FREE;
    if (ms == 2'b11) return s;
    if (s == E_FREE) return (ms == 2'b01) ? E_HOLD : E_NORM;
    if (ms == 2'b01 || chg) return E_HOLD;
    if (s == E_NORM && rise) return E_AUTO;
    if (s == E_HOLD && !fl) return E_NORM;
    if (s == E_AUTO && qd) return E_NORM;
    return s;
  endfunction

  task automatic model_step();
    logic [2:0] n;
    logic qd;
    if (rst) begin
      m_st = E_RST; m_cnt = 0; m_psel = 0; m_pfail = 0; m_fq = 0;
    end else begin
      qd = (m_st == E_AUTO) && (m_cnt >= run_len(m_fq));
      n = next_st(m_st, mode_sel, ref_sel != m_psel, ref_fail && !m_pfail, ref_fail, qd);
      if (m_st == E_AUTO && n == E_AUTO && !ref_fail && !phase_hit)
        m_cnt = (m_cnt >= run_len(m_fq)) ? run_len(m_fq) : m_cnt + 1;
      else
        m_cnt = 0;
      m_st = n; m_psel = ref_sel; m_pfail = ref_fail; m_fq = ref_freq;
    end
  endtask

  task automatic check(input string tag);
    logic exp_qd;
    exp_qd = (m_st == E_AUTO) && (m_cnt >= run_len(m_fq));
    n_chk++;
    if (state_code !== m_st || qual_done !== exp_qd) begin
      n_bad++;
      $display("FAIL %s: state=%b qual_done=%b expected state=%b qual_done=%b",
               tag, state_code, qual_done, m_st, exp_qd);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, check at the next falling edge.
  task automatic tick(input logic [1:0] ms, input logic rs, input logic fl,
                      input logic ph, input logic [1:0] fq, input logic rr,
                      input string tag);
    mode_sel = ms; ref_sel = rs; ref_fail = fl; phase_hit = ph; ref_freq = fq; rst = rr;
    model_step();
    @(negedge clk);
    check(tag);
  endtask

  task automatic run_clean(input int n, input logic [1:0] ms, input logic [1:0] fq,
                           input string tag);
    for (int i = 0; i < n; i++) tick(ms, ref_sel, 1'b0, 1'b0, fq, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_bad + 1, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    rst = 1; mode_sel = 0; ref_sel = 0; ref_fail = 0; phase_hit = 0; ref_freq = 0;
    m_st = E_RST; m_cnt = 0; m_psel = 0; m_pfail = 0; m_fq = 0;
    @(negedge clk);
    tick(2'b00, 0, 0, 0, 0, 1, "R1");
    tick(2'b01, 0, 1, 0, 0, 1, "R1");
    tick(2'b11, 1, 0, 0, 0, 0, "R2");            // Reset -> Free even with keep and a sel toggle
    tick(2'b11, 1, 0, 0, 0, 0, "R10");
    tick(2'b00, 0, 1, 0, 0, 0, "R4");            // sel toggle in Free ignored -> Normal
    tick(2'b00, 0, 1, 0, 0, 0, "R6");            // fail level held, no rise: stay Normal
    tick(2'b00, 0, 0, 0, 0, 0, "R6");
    tick(2'b00, 0, 1, 0, 0, 0, "R6");            // rise -> Auto
    tick(2'b00, 0, 0, 0, 0, 0, "R7");            // 8 kHz: one clean cycle qualifies
    tick(2'b00, 0, 0, 0, 0, 0, "R8");            // relock
    // 1.544 MHz run with a hit just before terminal count
    tick(2'b00, 0, 0, 0, 2'b01, 0, "R7");
    tick(2'b00, 0, 1, 0, 2'b01, 0, "R6");
    run_clean(62, 2'b00, 2'b01, "R7");
    tick(2'b00, 0, 0, 1, 2'b01, 0, "R7");        // hit clears
    run_clean(63, 2'b00, 2'b01, "R8");           // still one short
    tick(2'b00, 0, 0, 0, 2'b01, 0, "R7");        // 64th clean cycle: qual_done
    tick(2'b11, 0, 0, 0, 2'b01, 0, "R10");       // keep holds Auto
    tick(2'b11, 0, 0, 0, 2'b01, 0, "R10");
    tick(2'b00, 0, 0, 0, 2'b01, 0, "R8");
    // 19.44 MHz run with a failure reassertion
    tick(2'b00, 0, 0, 0, 2'b11, 0, "R7");
    tick(2'b00, 0, 1, 0, 2'b11, 0, "R6");
    run_clean(300, 2'b00, 2'b11, "R7");
    tick(2'b00, 0, 1, 0, 2'b11, 0, "R7");
    run_clean(511, 2'b00, 2'b11, "R7");
    tick(2'b00, 0, 0, 0, 2'b11, 0, "R7");
    tick(2'b00, 0, 0, 0, 2'b11, 0, "R8");
    // 2.048 MHz, then forced free-run from Auto
    tick(2'b00, 0, 1, 0, 2'b10, 0, "R6");
    run_clean(10, 2'b00, 2'b10, "R7");
    tick(2'b10, 0, 0, 0, 2'b10, 0, "R3");
    tick(2'b00, 0, 0, 0, 2'b10, 0, "R4");
    // Holdover entry and exit
    tick(2'b01, 0, 0, 0, 0, 0, "R5");
    tick(2'b00, 0, 1, 0, 0, 0, "R9");
    tick(2'b00, 0, 1, 0, 0, 0, "R9");
    tick(2'b00, 0, 0, 0, 0, 0, "R9");
    tick(2'b00, 1, 0, 0, 0, 0, "R5");            // sel toggle in Normal
    tick(2'b00, 0, 0, 0, 0, 0, "R11");           // toggle beats relock in Holdover
    tick(2'b00, 0, 0, 0, 0, 0, "R9");
    tick(2'b01, 0, 1, 0, 0, 0, "R11");           // hold request beats failure rise
    tick(2'b10, 1, 0, 0, 0, 0, "R11");           // forced free beats toggle
    tick(2'b01, 1, 0, 0, 0, 0, "R4");
    tick(2'b00, 1, 1, 0, 0, 0, "R9");
    tick(2'b00, 1, 0, 0, 0, 0, "R9");
    tick(2'b00, 1, 1, 0, 0, 0, "R6");
    tick(2'b00, 1, 1, 0, 0, 1, "R1");            // reset from Auto
    tick(2'b10, 1, 0, 0, 0, 0, "R3");            // from Reset
    // constrained random
    for (int i = 0; i < 5000; i++) begin
      int r;
      logic [1:0] ms;
      logic rs, fl, ph;
      logic [1:0] fq;
      r = int'($urandom % 100);
      ms = (r < 72) ? 2'b00 : (r < 82) ? 2'b01 : (r < 88) ? 2'b10 : 2'b11;
      rs = (($urandom % 100) < 2) ? ~ref_sel : ref_sel;
      fl = (($urandom % 100) < 4) ? ~ref_fail : ref_fail;
      ph = (($urandom % 100) < 2);
      fq = (($urandom % 100) < 1) ? 2'($urandom % 3) : ref_freq;
      tick(ms, rs, fl, ph, fq, 1'b0, "random R11");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule